// File: doc/BRIEF.md
# Masked Leading-Zero Count Unit

This execution unit takes a 64-bit source operand and a 64-bit mask operand. It reports how many mask-selected bit positions are zero in the source before the first selected position that holds a one, scanning from the most significant bit downward. Positions where the mask is zero are skipped completely. If no selected position of the source is one, the result is the number of ones in the mask.

The datapath has three stages. First, the source is ANDed with the mask and the leading zeros of that value are found. Next, the mask is shifted right so that only the selected positions above the first hit remain. Last, the remaining ones are counted. Requests use a valid/ready handshake. The result sits in a register with its own valid flag and holds until the consumer takes it.

A separate opcode-check output reports whether a 32-bit instruction word carries the matching register-form encoding. The arithmetic does not depend on it. A parameter selects one of two equivalent shifter structures.

Top module: `mask_lzc_unit`

## Requirements
- R1: The result equals the number of mask-one positions strictly above the most significant position where both source and mask are one.
- R2: When bit 63 of both the source and the mask is one, the result is 0.
- R3: When source AND mask is all zeros, the result is the population count of the mask; an all-zero mask gives 0.
- R4: The result never exceeds 64, and result bits 63:7 are always zero.
- R5: A request is accepted on a clock edge where req_valid and req_ready are both high, and res_valid is high with the result after that same edge.
- R6: While res_valid is high and res_ready is low, res_valid stays high and res_data does not change.
- R7: req_ready is high exactly when res_valid is low or res_ready is high, so a result can be consumed and a new request accepted in the same cycle.
- R8: A synchronous active-high reset clears res_valid and res_data to zero.
- R9: opc_match is high exactly when instruction bits 31:26 equal 31 and bits 10:1 equal 59; bit 0 has no effect.
- R10: insn_word and opc_match have no effect on res_data or res_valid.
- R11: When res_valid and res_ready are high and no request is accepted, res_valid is low after the edge and res_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request carries operands |
| req_ready | output | 1 | Unit can accept a request this cycle |
| src_op | input | 64 | Source operand |
| mask_op | input | 64 | Selection mask operand |
| insn_word | input | 32 | Instruction word for the opcode check |
| opc_match | output | 1 | Instruction word has the matching encoding |
| res_valid | output | 1 | Result register holds an unconsumed result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 64 | Registered count, zero-extended |

## Verification
The bench builds two copies of the unit with the default 64-bit width and the opcode check enabled. Instance u0 uses the XOR-and-fixed-shift window and u1 uses the subtract-based window, and one reference model checks both. Running the two shifter structures side by side covers the whole shift range from 0 to 64. This includes the all-zero masked value, where the two structures reach the answer by different paths, and the top-bit hit, where the whole window must be empty. Random stall and request patterns on the handshake also cover held results and results that are consumed and refilled in the same cycle.

// File: rtl/mlz_pkg.sv
package mlz_pkg;
   localparam int INSN_W = 32;

   typedef struct packed {
      logic [5:0] prim;
      logic [4:0] rt;
      logic [4:0] ra;
      logic [4:0] rb;
      logic [9:0] xop;
      logic       rc;
   } xform_t;

   typedef enum logic [0:0] {
      WIN_SUBTRACT = 1'b0,
      WIN_XOR_SPLIT = 1'b1
   } win_style_e;
endpackage

// File: rtl/mlz_lead_zero.sv
module mlz_lead_zero #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] lz,
   output logic          none
);
   always_comb begin
      lz = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) lz = CW'(W - 1 - i);
      end
   end
   assign none = ~|vec;
endmodule

// File: rtl/mlz_window.sv
module mlz_window
   import mlz_pkg::*;
#(
   parameter int         W     = 64,
   parameter int         CW    = $clog2(W + 1),
   parameter win_style_e STYLE = WIN_XOR_SPLIT
) (
   input  logic [W-1:0]  mask,
   input  logic [CW-1:0] lz,
   input  logic          none,
   output logic [W-1:0]  window
);
   localparam int SW = $clog2(W);

   generate
      if (STYLE == WIN_SUBTRACT) begin : g_sub
         logic [CW-1:0] shamt;
         assign shamt = CW'(W) - lz;
         always_comb begin
            if (lz == '0) window = '0;
            else          window = mask >> shamt;
         end
         logic unused_none;
         assign unused_none = none;
      end else begin : g_xor
         logic [SW-1:0] part;
         logic [W-1:0]  stage;
         assign part  = lz[SW-1:0] ^ {SW{1'b1}};
         assign stage = mask >> part;
         assign window = none ? mask : (stage >> 1);
      end
   endgenerate
endmodule

// File: rtl/mlz_popcount.sv
module mlz_popcount #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) ones = ones + CW'(vec[i]);
   end
endmodule

// File: rtl/mlz_opc_check.sv
module mlz_opc_check
   import mlz_pkg::*;
#(
   parameter int  PRIM_OP = 31,
   parameter int  EXT_OP  = 59,
   parameter bit  ENABLE  = 1'b1
) (
   input  logic [INSN_W-1:0] insn,
   output logic              hit
);
   xform_t f;
   assign f = xform_t'(insn);

   generate
      if (ENABLE) begin : g_on
         assign hit = (f.prim == 6'(PRIM_OP)) && (f.xop == 10'(EXT_OP));
      end else begin : g_off
         assign hit = 1'b0;
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{f.rt, f.ra, f.rb, f.rc};
endmodule

// File: rtl/mask_lzc_unit.sv
module mask_lzc_unit
   import mlz_pkg::*;
#(
   parameter int         DATA_W    = 64,
   parameter win_style_e WIN_STYLE = WIN_XOR_SPLIT,
   parameter bit         OPC_EN    = 1'b1,
   parameter int         PRIM_OP   = 31,
   parameter int         EXT_OP    = 59
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [DATA_W-1:0]   src_op,
   input  logic [DATA_W-1:0]   mask_op,
   input  logic [INSN_W-1:0]   insn_word,
   output logic                opc_match,
   output logic                res_valid,
   input  logic                res_ready,
   output logic [DATA_W-1:0]   res_data
);
   localparam int CW = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("mask_lzc_unit: DATA_W must be a power of two of at least 8");
      end
      if (PRIM_OP < 0 || PRIM_OP > 63 || EXT_OP < 0 || EXT_OP > 1023) begin : g_bad_opc
         $error("mask_lzc_unit: opcode parameters out of field range");
      end
   endgenerate

   logic [DATA_W-1:0] sel;
   logic [CW-1:0]     lz;
   logic              none;
   logic [DATA_W-1:0] window;
   logic [CW-1:0]     ones;
   logic [CW-1:0]     cnt_q;
   logic              val_q;
   logic              take;

   assign sel = src_op & mask_op;

   mlz_lead_zero #(.W(DATA_W), .CW(CW)) u_lz (
      .vec (sel),
      .lz  (lz),
      .none(none)
   );

   mlz_window #(.W(DATA_W), .CW(CW), .STYLE(WIN_STYLE)) u_win (
      .mask  (mask_op),
      .lz    (lz),
      .none  (none),
      .window(window)
   );

   mlz_popcount #(.W(DATA_W), .CW(CW)) u_pop (
      .vec (window),
      .ones(ones)
   );

   mlz_opc_check #(.PRIM_OP(PRIM_OP), .EXT_OP(EXT_OP), .ENABLE(OPC_EN)) u_opc (
      .insn(insn_word),
      .hit (opc_match)
   );

   assign req_ready = !val_q || res_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         val_q <= 1'b0;
         cnt_q <= '0;
      end else if (take) begin
         val_q <= 1'b1;
         cnt_q <= ones;
      end else if (res_ready) begin
         val_q <= 1'b0;
      end
   end

   assign res_valid = val_q;
   assign res_data  = {{(DATA_W - CW){1'b0}}, cnt_q};
endmodule

// File: rtl/mlz_checker.sv
module mlz_checker #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [DATA_W-1:0] src_op,
   input logic [DATA_W-1:0] mask_op,
   input logic              res_valid,
   input logic              res_ready,
   input logic [DATA_W-1:0] res_data
);
   AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> res_valid); // R5

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R6

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> req_ready); // R7

   AST_TOP_HIT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && src_op[DATA_W-1] && mask_op[DATA_W-1]) |=> (res_data == '0)); // R2

   AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && mask_op == '0) |=> (res_data == '0)); // R3

   AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_ready && !req_valid) |=> (!res_valid && $stable(res_data))); // R11
endmodule

bind mask_lzc_unit mlz_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .src_op   (src_op),
   .mask_op  (mask_op),
   .res_valid(res_valid),
   .res_ready(res_ready),
   .res_data (res_data)
);

// File: tb/sim_mask_lzc_unit.sv
module sim_mask_lzc_unit;
   import mlz_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        res_ready = 1'b0;
   logic [63:0] src_op = '0;
   logic [63:0] mask_op = '0;
   logic [31:0] insn_word = '0;
   logic        req_ready, req_ready_b;
   logic        opc_match, opc_match_b;
   logic        res_valid, res_valid_b;
   logic [63:0] res_data, res_data_b;

   always #5 clk = ~clk;

   mask_lzc_unit #(.WIN_STYLE(WIN_XOR_SPLIT)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .src_op(src_op), .mask_op(mask_op), .insn_word(insn_word),
      .opc_match(opc_match), .res_valid(res_valid), .res_ready(res_ready),
      .res_data(res_data)
   );

   mask_lzc_unit #(.WIN_STYLE(WIN_SUBTRACT)) u1 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready_b),
      .src_op(src_op), .mask_op(mask_op), .insn_word(insn_word),
      .opc_match(opc_match_b), .res_valid(res_valid_b), .res_ready(res_ready),
      .res_data(res_data_b)
   );

   int checks = 0;
   int errors = 0;

   // Reference: walk down from the top, counting selected positions until a hit.
   function automatic logic [63:0] ref_count(logic [63:0] s, logic [63:0] m);
      int c = 0;
      for (int i = 63; i >= 0; i--) begin
         if (s[i] && m[i]) return 64'(c);
         if (m[i]) c++;
      end
      return 64'(c);
   endfunction

   function automatic string ref_tag(logic [63:0] s, logic [63:0] m);
      if ((s[63] && m[63])) return "R2";
      if ((s & m) == '0) return "R3";
      return "R1";
   endfunction

   // Reference model, updated on every clock
   logic        exp_valid = 1'b0;
   logic [63:0] exp_data = '0;
   logic [63:0] last_src = '0;
   logic [63:0] last_mask = '0;
   logic        exp_ready;
   assign exp_ready = !exp_valid || res_ready;

   always @(posedge clk) begin
      if (rst) begin
         exp_valid <= 1'b0;
         exp_data  <= '0;
         last_src  <= '0;
         last_mask <= '0;
      end else if (req_valid && exp_ready) begin
         exp_valid <= 1'b1;
         exp_data  <= ref_count(src_op, mask_op);
         last_src  <= src_op;
         last_mask <= mask_op;
      end else if (res_ready) begin
         exp_valid <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Drive inputs (at negedge), check combinational outputs, clock, check registers.
   task automatic cyc(input string tag);
      string t;
      #1;
      chk(req_ready == exp_ready, "R7 req_ready u0", 64'(req_ready), 64'(exp_ready));
      chk(req_ready_b == exp_ready, "R7 req_ready u1", 64'(req_ready_b), 64'(exp_ready));
      chk(opc_match == ((insn_word[31:26] == 6'd31) && (insn_word[10:1] == 10'd59)),
          "R9 opc_match", 64'(opc_match),
          64'((insn_word[31:26] == 6'd31) && (insn_word[10:1] == 10'd59)));
      @(posedge clk);
      @(negedge clk);
      t = (tag != "") ? tag : ref_tag(last_src, last_mask);
      chk(res_valid == exp_valid, {t, " res_valid u0"}, 64'(res_valid), 64'(exp_valid));
      chk(res_valid_b == exp_valid, {t, " res_valid u1"}, 64'(res_valid_b), 64'(exp_valid));
      chk(res_data == exp_data, {t, " res_data u0"}, res_data, exp_data);
      chk(res_data_b == exp_data, {t, " res_data u1"}, res_data_b, exp_data);
      chk(res_data[63:7] == '0 && res_data <= 64, "R4 range", res_data, exp_data);
   endtask

   task automatic req(input logic [63:0] s, input logic [63:0] m, input string tag);
      req_valid = 1'b1; res_ready = 1'b1; src_op = s; mask_op = m;
      cyc(tag);
      req_valid = 1'b0;
   endtask

   function automatic logic [31:0] make_insn(logic [5:0] p, logic [9:0] x, logic rc);
      return {p, 5'd3, 5'd4, 5'd5, x, rc};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      rst = 1'b1;
      cyc("R8");
      cyc("R8");
      rst = 1'b0;
      cyc("R8");

      // Directed corner cases
      req('1, '1, "R2");
      req('0, '1, "R3");
      req('1, '0, "R3");
      req(64'h1, '1, "R1");
      req(64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_0000, "R3");
      req(64'h0000_0000_0001_0000, 64'hF0F0_0000_0003_0000, "R1");
      req(64'h4000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R1");
      req(64'h0, 64'h8000_0000_0000_0001, "R3");

      // Hold while consumer stalls
      req_valid = 1'b1; res_ready = 1'b1; src_op = 64'h10; mask_op = 64'hFF;
      cyc("R5");
      req_valid = 1'b1; res_ready = 1'b0; src_op = 64'h1; mask_op = '1;
      cyc("R6");
      cyc("R6");
      req_valid = 1'b0;
      cyc("R6");
      // Consume with no new request
      res_ready = 1'b1;
      cyc("R11");
      cyc("R11");

      // Opcode check and independence of the result
      insn_word = make_insn(6'd31, 10'd59, 1'b0);
      req(64'h0F00, 64'hFFFF, "R10");
      insn_word = make_insn(6'd31, 10'd59, 1'b1);
      req(64'h0F00, 64'hFFFF, "R10");
      insn_word = make_insn(6'd30, 10'd59, 1'b0);
      req(64'h0F00, 64'hFFFF, "R10");
      insn_word = make_insn(6'd31, 10'd58, 1'b0);
      req(64'h0F00, 64'hFFFF, "R10");

      // Reset while a result is pending
      req_valid = 1'b1; res_ready = 1'b0; src_op = 64'h3; mask_op = 64'hF;
      cyc("R5");
      req_valid = 1'b0; rst = 1'b1;
      cyc("R8");
      rst = 1'b0;

      // Random traffic
      for (int k = 0; k < 2000; k++) begin
         logic [63:0] s, m;
         s = {$urandom, $urandom};
         m = {$urandom, $urandom};
         case (k % 4)
            0: s = s & (s >> 7) & (s >> 13);
            1: m = m & (m << 3);
            2: s = '0;
            default: ;
         endcase
         src_op    = s;
         mask_op   = m;
         req_valid = ($urandom % 4) != 0;
         res_ready = ($urandom % 3) != 0;
         insn_word = ($urandom % 2) ? make_insn(6'd31, 10'd59, 1'($urandom))
                                    : 32'($urandom);
         cyc("");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule